// File: doc/BRIEF.md
# SPI Card Block Reader

This block collects the data phase of a memory-card read over SPI, after the card has accepted a read command. A start strobe loads a block count, a block size in bytes and a CRC-check enable. For each block the reader clocks bytes out of the card through a byte-wide SPI master handshake. It skips idle bytes until the start token appears, and then passes the payload to a streaming byte output. It then takes the two trailing check bytes and compares them with a CRC computed over the payload.

The SPI master is outside this block, and chip select is also handled elsewhere. The reader holds `spi_req` high whenever it wants another byte and always offers 0xFF as the byte to transmit. The master answers each byte with a one-cycle `spi_done` and the received value on `spi_rx`. When the run ends, the reader emits a one-cycle `done` pulse with a status code. The run ends when every block has been read, when a CRC mismatch occurs, or when a token fault or poll timeout occurs.

Top module: `card_block_reader`

## Requirements
- R1: After reset the block is idle: `spi_req`, `data_valid`, `done` and `busy` are low and `status` is 0.
- R2: Every byte the block requests is transmitted as 0xFF, so `spi_tx` is 0xFF whenever `spi_req` is high.
- R3: While looking for a block, received 0xFF bytes are skipped. A received 0xFE starts the payload of that block.
- R4: If the first byte other than 0xFF in a hunt is not 0xFE, the run ends with `done` and status 2, and no payload strobe is produced for that block.
- R5: A hunt that receives POLL_LIMIT consecutive 0xFF bytes ends the run with status 2. POLL_LIMIT-1 idle bytes followed by 0xFE still start the block. The poll count restarts for every block.
- R6: After the token, exactly `blk_size` bytes (1 or more) are presented on `data_out` in arrival order, each with a one-cycle `data_valid`. Token, idle and CRC bytes never raise `data_valid`.
- R7: With `crc_en` high at start, the CRC16 over each payload is computed with polynomial 0x1021, a zero seed and most significant bit first. It is compared with the two bytes after the payload, which arrive high byte first. A mismatch ends the run with status 1, and no byte of any later block is requested.
- R8: With `crc_en` low at start, the received CRC bytes are consumed but their value has no effect on the status.
- R9: A run of `blk_count` blocks that all pass ends with status 0 after the last block's CRC bytes.
- R10: A start with `blk_count` of 0 produces `done` with status 0 on the next cycle, and no byte is requested.
- R11: A start strobe while a run is in progress is ignored.
- R12: `done` is high for exactly one cycle per run. `status` keeps its value after `done` until the next run completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run, sampled when idle |
| blk_count | input | CNT_W | Number of blocks to read |
| blk_size | input | SIZE_W | Payload bytes per block, at least 1 |
| crc_en | input | 1 | Enable payload CRC comparison |
| spi_req | output | 1 | Request for another SPI byte |
| spi_tx | output | 8 | Byte to transmit (always 0xFF) |
| spi_done | input | 1 | One-cycle completion of a requested byte |
| spi_rx | input | 8 | Byte received with `spi_done` |
| data_out | output | 8 | Payload byte |
| data_valid | output | 1 | `data_out` holds a new payload byte |
| done | output | 1 | One-cycle end-of-run pulse |
| status | output | 2 | 0 ok, 1 CRC mismatch, 2 token fault or timeout |
| busy | output | 1 | A run is in progress |

## Verification
Two decisions meet on the arrival of a block's low CRC byte: the CRC verdict and the step of the block counter that selects between a new hunt and a finished run. The bench provokes this with a master that answers with no idle cycles, and it corrupts the CRC of a middle block so that more blocks remain. The run is judged correct only if the status is the CRC code, the payload bytes of the first two blocks are delivered and nothing later is, and `spi_req` has dropped on the cycle after `done`. The same collision is also run with checking disabled, and in that case all blocks must flow through with status 0.

// File: rtl/card_rx_pkg.sv
package card_rx_pkg;
   typedef enum logic [1:0] {
      RX_OK        = 2'd0,
      RX_CRC_BAD   = 2'd1,
      RX_TOKEN_BAD = 2'd2
   } rx_status_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HUNT,
      ST_DATA,
      ST_CRC_HI,
      ST_CRC_LO
   } rx_state_e;

   localparam logic [7:0] FILL_BYTE   = 8'hFF;
   localparam logic [7:0] START_TOKEN = 8'hFE;
endpackage

// File: rtl/card_rx_crc16.sv
module card_rx_crc16 #(
   parameter logic [15:0] POLY = 16'h1021
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clear,
   input  logic        step,
   input  logic [7:0]  din,
   output logic [15:0] crc
);
   logic [15:0]      crc_q;
   logic [8:0][15:0] chain;

   assign chain[0] = crc_q;

   // one shift stage per input bit, most significant bit first
   for (genvar b = 0; b < 8; b++) begin : g_bit
      logic fb;
      assign fb           = chain[b][15] ^ din[7-b];
      assign chain[b+1]   = {chain[b][14:0], 1'b0} ^ (fb ? POLY : 16'h0000);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     crc_q <= '0;
      else if (clear) crc_q <= '0;
      else if (step)  crc_q <= chain[8];
   end

   assign crc = crc_q;
endmodule

// File: rtl/card_rx_down.sv
module card_rx_down #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic         last
);
   logic [W-1:0] value_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    value_q <= '0;
      else if (load) value_q <= load_val;
      else if (dec)  value_q <= value_q - 1'b1;
   end

   assign last = (value_q == W'(1));

   // R6 R9: a counted item never arrives once the count is exhausted
   cnt_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load) |-> (value_q != '0));
endmodule

// File: rtl/card_rx_poll.sv
module card_rx_poll #(
   parameter int LIMIT = 3000000,
   localparam int PW   = $clog2(LIMIT)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic tick,
   output logic at_limit
);
   logic [PW-1:0] cnt_q;

   assign at_limit = (cnt_q == PW'(LIMIT - 1));

   always_ff @(posedge clk) begin
      if (!rst_n)                cnt_q <= '0;
      else if (clear)            cnt_q <= '0;
      else if (tick && !at_limit) cnt_q <= cnt_q + 1'b1;
   end

   // R5
   poll_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= PW'(LIMIT - 1));
endmodule

// File: rtl/card_block_reader.sv
module card_block_reader
   import card_rx_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int SIZE_W     = 12,
   parameter int POLL_LIMIT = 3000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [CNT_W-1:0]  blk_count,
   input  logic [SIZE_W-1:0] blk_size,
   input  logic              crc_en,
   output logic              spi_req,
   output logic [7:0]        spi_tx,
   input  logic              spi_done,
   input  logic [7:0]        spi_rx,
   output logic [7:0]        data_out,
   output logic              data_valid,
   output logic              done,
   output logic [1:0]        status,
   output logic              busy
);
   if (POLL_LIMIT < 2) begin : g_bad_poll
      $error("POLL_LIMIT must be at least 2");
   end
   if (CNT_W < 1 || SIZE_W < 1) begin : g_bad_width
      $error("CNT_W and SIZE_W must be positive");
   end

   rx_state_e         state_q;
   rx_status_e        status_q;
   logic [SIZE_W-1:0] size_q;
   logic              crc_en_q;
   logic [7:0]        crc_hi_q;
   logic [15:0]       crc_val;
   logic              poll_at_limit, bytes_last, blocks_last;
   logic              got_token, got_fill, take_data, crc_step_ok, crc_good;

   assign got_fill    = (state_q == ST_HUNT) && spi_done && (spi_rx == FILL_BYTE);
   assign got_token   = (state_q == ST_HUNT) && spi_done && (spi_rx == START_TOKEN);
   assign take_data   = (state_q == ST_DATA) && spi_done;
   assign crc_good    = !crc_en_q || ({crc_hi_q, spi_rx} == crc_val);
   assign crc_step_ok = (state_q == ST_CRC_LO) && spi_done && crc_good;

   card_rx_poll #(.LIMIT(POLL_LIMIT)) u_poll (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (state_q != ST_HUNT),
      .tick     (got_fill),
      .at_limit (poll_at_limit)
   );

   card_rx_down #(.W(SIZE_W)) u_bytes (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (got_token),
      .load_val (size_q),
      .dec      (take_data),
      .last     (bytes_last)
   );

   card_rx_down #(.W(CNT_W)) u_blocks (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     ((state_q == ST_IDLE) && start),
      .load_val (blk_count),
      .dec      (crc_step_ok),
      .last     (blocks_last)
   );

   card_rx_crc16 #(.POLY(16'h1021)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (got_token),
      .step  (take_data),
      .din   (spi_rx),
      .crc   (crc_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         status_q   <= RX_OK;
         size_q     <= '0;
         crc_en_q   <= 1'b0;
         crc_hi_q   <= '0;
         data_out   <= '0;
         data_valid <= 1'b0;
         done       <= 1'b0;
      end else begin
         done       <= 1'b0;
         data_valid <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start) begin
               crc_en_q <= crc_en;
               size_q   <= blk_size;
               if (blk_count == '0) begin
                  done     <= 1'b1;
                  status_q <= RX_OK;
               end else begin
                  state_q  <= ST_HUNT;
               end
            end
            ST_HUNT: if (spi_done) begin
               if (spi_rx == START_TOKEN) begin
                  state_q <= ST_DATA;
               end else if (spi_rx != FILL_BYTE || poll_at_limit) begin
                  state_q  <= ST_IDLE;
                  status_q <= RX_TOKEN_BAD;
                  done     <= 1'b1;
               end
            end
            ST_DATA: if (spi_done) begin
               data_out   <= spi_rx;
               data_valid <= 1'b1;
               if (bytes_last) state_q <= ST_CRC_HI;
            end
            ST_CRC_HI: if (spi_done) begin
               crc_hi_q <= spi_rx;
               state_q  <= ST_CRC_LO;
            end
            ST_CRC_LO: if (spi_done) begin
               if (!crc_good) begin
                  state_q  <= ST_IDLE;
                  status_q <= RX_CRC_BAD;
                  done     <= 1'b1;
               end else if (blocks_last) begin
                  state_q  <= ST_IDLE;
                  status_q <= RX_OK;
                  done     <= 1'b1;
               end else begin
                  state_q  <= ST_HUNT;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign spi_req = (state_q != ST_IDLE);
   assign busy    = (state_q != ST_IDLE);
   assign spi_tx  = FILL_BYTE;
   assign status  = status_q;

   // R6
   payload_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |-> $past(state_q == ST_DATA && spi_done));

   // R12
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (state_q == ST_IDLE && !spi_req));

   // R8
   crc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == RX_CRC_BAD) |-> crc_en_q);

   // R6
   strobe_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid |-> (state_q == ST_DATA || state_q == ST_CRC_HI));
endmodule

// File: tb/card_block_reader_test.sv
module card_block_reader_test;
   localparam int CLK_PERIOD = 10;
   localparam int POLL_LIM   = 16;
   localparam int CNT_W      = 8;
   localparam int SIZE_W     = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [CNT_W-1:0]  blk_count = '0;
   logic [SIZE_W-1:0] blk_size = '0;
   logic              crc_en = 1'b0;
   logic              spi_req;
   logic [7:0]        spi_tx;
   logic              spi_done = 1'b0;
   logic [7:0]        spi_rx = 8'hFF;
   logic [7:0]        data_out;
   logic              data_valid, done, busy;
   logic [1:0]        status;

   card_block_reader #(.CNT_W(CNT_W), .SIZE_W(SIZE_W), .POLL_LIMIT(POLL_LIM)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .blk_count(blk_count),
      .blk_size(blk_size), .crc_en(crc_en), .spi_req(spi_req), .spi_tx(spi_tx),
      .spi_done(spi_done), .spi_rx(spi_rx), .data_out(data_out),
      .data_valid(data_valid), .done(done), .status(status), .busy(busy)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   logic [7:0] rx_q[$];
   logic [7:0] exp_q[$];
   int gap = 0;
   int gap_left = 0;
   int n_checks = 0;
   int n_fail = 0;
   bit tx_bad = 1'b0;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r = c;
      for (int k = 7; k >= 0; k--) begin
         logic fb = r[15] ^ b[k];
         r = {r[14:0], 1'b0};
         if (fb) r = r ^ 16'h1021;
      end
      return r;
   endfunction

   // card model: answers each requested byte from the queue, idle bytes when empty
   always @(negedge clk) begin
      if (spi_req && gap_left == 0) begin
         spi_done <= 1'b1;
         spi_rx   <= (rx_q.size() > 0) ? rx_q.pop_front() : 8'hFF;
         gap_left = gap;
      end else begin
         spi_done <= 1'b0;
         if (gap_left > 0) gap_left = gap_left - 1;
      end
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (spi_req && spi_tx != 8'hFF) tx_bad = 1'b1;
      if (data_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R6", "unexpected payload strobe", data_out, -1);
         end else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(data_out == e, "R6", "payload byte", data_out, e);
         end
      end
   end

   task automatic push_block(input int size, input int seed, input int n_ff,
                             input bit corrupt, input bit deliver);
      logic [15:0] c = 16'h0000;
      for (int i = 0; i < n_ff; i++) rx_q.push_back(8'hFF);
      rx_q.push_back(8'hFE);
      for (int i = 0; i < size; i++) begin
         logic [7:0] b;
         b = 8'(seed * 29 + i * 7 + 3);
         rx_q.push_back(b);
         if (deliver) exp_q.push_back(b);
         c = crc_upd(c, b);
      end
      if (corrupt) c = c ^ 16'h0100;
      rx_q.push_back(c[15:8]);
      rx_q.push_back(c[7:0]);
   endtask

   task automatic start_op(input int cnt, input int size, input bit en);
      @(negedge clk);
      blk_count = CNT_W'(cnt);
      blk_size  = SIZE_W'(size);
      crc_en    = en;
      start     = 1'b1;
      @(negedge clk);
      start     = 1'b0;
   endtask

   task automatic wait_done(input int exp_status, input string tag);
      int t = 0;
      logic [1:0] st;
      while (!done && t < 3000) begin
         @(negedge clk);
         t++;
      end
      check(done == 1'b1, tag, "done seen", done, 1);
      check(status == 2'(exp_status), tag, "status", status, exp_status);
      st = status;
      @(negedge clk);
      check(done == 1'b0, "R12", "done one cycle", done, 0);
      check(status == st, "R12", "status held", status, st);
      check(spi_req == 1'b0, tag, "no request after done", spi_req, 0);
      check(exp_q.size() == 0, tag, "payload bytes missing", exp_q.size(), 0);
      check(tx_bad == 1'b0, "R2", "transmit byte 0xFF", tx_bad, 0);
      tx_bad = 1'b0;
      rx_q.delete();
      exp_q.delete();
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check(spi_req == 0 && data_valid == 0 && done == 0 && busy == 0, "R1",
            "idle outputs", {spi_req, data_valid, done, busy}, 0);
      check(status == 2'd0, "R1", "reset status", status, 0);

      // R3 R6 R7: single block, back-to-back bytes
      gap = 0;
      push_block(8, 1, 3, 1'b0, 1'b1);
      start_op(1, 8, 1'b1);
      wait_done(0, "R3");

      // R9: three blocks with idle cycles between bytes
      gap = 2;
      push_block(5, 2, 1, 1'b0, 1'b1);
      push_block(5, 3, 4, 1'b0, 1'b1);
      push_block(5, 4, 0, 1'b0, 1'b1);
      start_op(3, 5, 1'b1);
      wait_done(0, "R9");

      // R4: wrong token
      gap = 0;
      rx_q.push_back(8'hFF);
      rx_q.push_back(8'hFF);
      rx_q.push_back(8'hF0);
      for (int i = 0; i < 6; i++) rx_q.push_back(8'(i));
      start_op(1, 4, 1'b1);
      wait_done(2, "R4");

      // R5: one idle byte short of the limit, in each of two blocks
      push_block(4, 5, POLL_LIM - 1, 1'b0, 1'b1);
      push_block(4, 6, POLL_LIM - 1, 1'b0, 1'b1);
      start_op(2, 4, 1'b1);
      wait_done(0, "R5");

      // R5: exactly the limit of idle bytes before the token
      push_block(4, 7, POLL_LIM, 1'b0, 1'b0);
      start_op(1, 4, 1'b1);
      wait_done(2, "R5");

      // R5: card never answers
      start_op(2, 4, 1'b1);
      wait_done(2, "R5");

      // R7: middle block CRC corrupted, back-to-back bytes
      gap = 0;
      push_block(6, 8, 2, 1'b0, 1'b1);
      push_block(6, 9, 2, 1'b1, 1'b1);
      push_block(6, 10, 2, 1'b0, 1'b0);
      start_op(3, 6, 1'b1);
      wait_done(1, "R7");

      // R8: same corruption with checking off
      push_block(6, 8, 2, 1'b0, 1'b1);
      push_block(6, 9, 2, 1'b1, 1'b1);
      push_block(6, 10, 2, 1'b0, 1'b1);
      start_op(3, 6, 1'b0);
      wait_done(0, "R8");

      // R10: zero blocks
      start_op(0, 4, 1'b1);
      check(spi_req == 1'b0, "R10", "no request", spi_req, 0);
      wait_done(0, "R10");

      // R11: start during a run is ignored
      gap = 3;
      push_block(6, 11, 1, 1'b0, 1'b1);
      push_block(6, 12, 1, 1'b0, 1'b1);
      push_block(6, 13, 1, 1'b0, 1'b1);
      start_op(3, 6, 1'b1);
      repeat (10) @(negedge clk);
      blk_count = '0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1'b1 && done == 1'b0, "R11", "run continues", busy, 1);
      wait_done(0, "R11");

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule